// File: doc/BRIEF.md
# Flash Erase and Bank Controller

This block sits between an 8-bit microcontroller core and an on-chip flash array. Software uses a byte-wide special-function-register port to reach a small set of control registers. These hold the flash bank select, the page to erase, a mass-erase arming bit, a program-write steering bit and an erase command register. The block maps the upper 32 KB window of the 16-bit code address space onto the selected flash bank. It steers external data-move writes either to data RAM or to program flash.

Erase is guarded in three ways. A command starts only on a specific byte pattern. The command also needs a matching arming write made beforehand, and each arming is used up by one erase. The request goes to the flash macro over a valid/ready channel: `erase_valid` rises with the kind and page number and holds them steady until `erase_ready` is seen high at a clock edge. The ready input may stay low for any number of cycles. The block stays busy until the flash reports done and software has also written the completion value. Commands that are rejected are counted so that a test can observe them.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After an active-low reset, the bank select, page field, both arming flags, the steering bit, the reject count and `busy` are all zero, and `erase_valid` is low.
- R2: When `cpu_addr[15]` is 1, `flash_addr` is the bank select followed by `cpu_addr[14:0]`. Otherwise the bank bits of `flash_addr` are zero. The bank select is written at register 0x10, bits [1:0], and reads back there.
- R3: A data-move write strobe `xwr_req` drives `flash_wr` when the steering bit is 1 and `xram_wr` when it is 0. The two outputs are never high together. The steering bit is register 0x12 bit 0.
- R4: A write to register 0x12 leaves the steering bit unchanged while `irq_en` is 1.
- R5: Writing 0x55 to the command register 0x11 starts a page erase only if the page-arming flag is set. From the next cycle `busy` and `erase_valid` are high, `erase_mass` is 0, and `erase_page` is {bank bit 0, page field}. The page field is register 0x13 bits [7:2].
- R6: Writing 0xAA to register 0x11 starts a mass erase only if the mass-arming flag is set and `dbg_en` is 1. `erase_mass` is then 1. The mass-arming flag is register 0x12 bit 1, and it also reads back at that bit.
- R7: A nonzero command that starts nothing has no other effect. This covers other patterns, unarmed commands and any command while busy. Each such command adds one to `rej_cnt`, and the count saturates at its maximum.
- R8: Any write to register 0x13 sets the page-arming flag, and starting a page erase clears it. Starting a mass erase clears the mass-arming flag. A rejected command clears neither flag.
- R9: The bank select reads 0 once an erase has started.
- R10: `busy` stays high until `flash_done` has been seen and 0x00 has been written to register 0x11, in either order. `erase_valid` holds until `erase_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address for write and read |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Combinational read data for `sfr_addr` |
| irq_en | input | 1 | CPU interrupts enabled |
| dbg_en | input | 1 | Debug port enabled |
| cpu_addr | input | 16 | CPU code address |
| xwr_req | input | 1 | Data-move write strobe |
| flash_addr | output | 17 | Mapped flash address |
| flash_wr | output | 1 | Steered write to program flash |
| xram_wr | output | 1 | Steered write to data RAM |
| erase_valid | output | 1 | Erase request valid |
| erase_ready | input | 1 | Flash accepts erase request |
| erase_mass | output | 1 | Request kind: 1 mass, 0 page |
| erase_page | output | 7 | Page number to erase |
| flash_done | input | 1 | Flash reports erase finished |
| busy | output | 1 | Erase in progress |
| arm_page | output | 1 | Page-erase arming flag |
| arm_mass | output | 1 | Mass-erase arming flag |
| rej_cnt | output | 8 | Saturating count of rejected commands |

## Verification
The assertions check several rules on every cycle. The two write steering outputs are exclusive. The steering bit is frozen while interrupts are enabled, and the request payload holds under back-pressure. The page arming flag falls only on a page command. The bank reads zero whenever busy rises, a mass erase never starts without the debug port, and busy only falls on a done pulse or a completion write. The reject count also never moves by more than one per cycle. Other behaviours need the bench's scenarios to show them. These are that arming really is single-use across back-to-back commands, the exact page number sent for a given bank and page field, and that completion works in both orders of done and the zero write. They also include saturation of the reject count and that every rejected command leaves the registers untouched.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam logic [7:0] A_BANK  = 8'h10;
  localparam logic [7:0] A_ERASE = 8'h11;
  localparam logic [7:0] A_CTRL  = 8'h12;
  localparam logic [7:0] A_PAGE  = 8'h13;

  localparam logic [7:0] CMD_PAGE = 8'h55;
  localparam logic [7:0] CMD_MASS = 8'hAA;
  localparam logic [7:0] CMD_DONE = 8'h00;

  localparam int CTRL_PWE_BIT  = 0;
  localparam int CTRL_MASS_BIT = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RUN} er_state_t;
endpackage

// File: rtl/fec_regs.sv
module fec_regs
  import fec_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int PG_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              irq_en,
  input  logic              take_page,
  input  logic              take_mass,
  input  logic              clear_bank,
  output logic [BANK_W-1:0] bank_q,
  output logic [PG_W-1:0]   pgadr_q,
  output logic              arm_page_q,
  output logic              arm_mass_q,
  output logic              pwe_q,
  output logic [7:0]        rdata
);
  localparam int BANK_PAD = 8 - BANK_W;
  localparam int PG_PAD   = 8 - PG_W;

  logic wr_bank, wr_ctrl, wr_page;
  assign wr_bank = we && (addr == A_BANK);
  assign wr_ctrl = we && (addr == A_CTRL);
  assign wr_page = we && (addr == A_PAGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q     <= '0;
      pgadr_q    <= '0;
      arm_page_q <= 1'b0;
      arm_mass_q <= 1'b0;
      pwe_q      <= 1'b0;
    end else begin
      if (clear_bank)   bank_q <= '0;
      else if (wr_bank) bank_q <= wdata[BANK_W-1:0];

      if (wr_page) pgadr_q <= wdata[7 -: PG_W];

      if (take_page)    arm_page_q <= 1'b0;
      else if (wr_page) arm_page_q <= 1'b1;

      if (take_mass)    arm_mass_q <= 1'b0;
      else if (wr_ctrl) arm_mass_q <= wdata[CTRL_MASS_BIT];

      if (wr_ctrl && !irq_en) pwe_q <= wdata[CTRL_PWE_BIT];
    end
  end

  always_comb begin
    rdata = 8'h00;
    unique case (addr)
      A_BANK:  rdata = {{BANK_PAD{1'b0}}, bank_q};
      A_CTRL:  rdata = {6'b0, arm_mass_q, pwe_q};
      A_PAGE:  rdata = {pgadr_q, {PG_PAD{1'b0}}};
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/fec_seq.sv
module fec_seq
  import fec_pkg::*;
#(
  parameter int PG_W  = 6,
  parameter int CNT_W = 8,
  localparam int PAGE_W = PG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic [7:0]        wdata,
  input  logic              arm_page,
  input  logic              arm_mass,
  input  logic              dbg_en,
  input  logic              bank_lsb,
  input  logic [PG_W-1:0]   pgadr,
  input  logic              erase_ready,
  input  logic              flash_done,
  output logic              start_page,
  output logic              start_mass,
  output logic              busy,
  output logic              erase_valid,
  output logic              erase_mass,
  output logic [PAGE_W-1:0] erase_page,
  output logic [CNT_W-1:0]  rej_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  er_state_t state_q;
  logic      zero_seen_q, done_seen_q;
  logic      idle, zero_wr, reject, fin_zero, fin_done;

  assign idle       = (state_q == ST_IDLE);
  assign start_page = wr_cmd && idle && (wdata == CMD_PAGE) && arm_page;
  assign start_mass = wr_cmd && idle && (wdata == CMD_MASS) && arm_mass && dbg_en;
  assign zero_wr    = wr_cmd && (wdata == CMD_DONE);
  assign reject     = wr_cmd && !zero_wr && !start_page && !start_mass;
  assign fin_zero   = zero_seen_q || zero_wr;
  assign fin_done   = done_seen_q || flash_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      zero_seen_q <= 1'b0;
      done_seen_q <= 1'b0;
      erase_mass  <= 1'b0;
      erase_page  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_page || start_mass) begin
            state_q     <= ST_REQ;
            zero_seen_q <= 1'b0;
            done_seen_q <= 1'b0;
            erase_mass  <= start_mass;
            erase_page  <= start_mass ? '0 : {bank_lsb, pgadr};
          end
        end
        ST_REQ: begin
          if (zero_wr) zero_seen_q <= 1'b1;
          if (erase_ready) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (fin_zero && fin_done) begin
            state_q <= ST_IDLE;
          end else begin
            zero_seen_q <= fin_zero;
            done_seen_q <= fin_done;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          rej_cnt <= '0;
    else if (reject && rej_cnt != CNT_MAX) rej_cnt <= rej_cnt + 1'b1;
  end

  assign busy        = !idle;
  assign erase_valid = (state_q == ST_REQ);
endmodule

// File: rtl/fec_map.sv
module fec_map #(
  parameter int BANK_W = 2,
  parameter int CPU_AW = 16,
  localparam int LOW_W    = CPU_AW - 1,
  localparam int FLASH_AW = BANK_W + LOW_W
) (
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic [BANK_W-1:0]   bank,
  input  logic                xwr_req,
  input  logic                pwe,
  output logic [FLASH_AW-1:0] flash_addr,
  output logic                flash_wr,
  output logic                xram_wr
);
  logic upper;
  assign upper      = cpu_addr[CPU_AW-1];
  assign flash_addr = upper ? {bank, cpu_addr[LOW_W-1:0]}
                            : {{BANK_W{1'b0}}, cpu_addr[LOW_W-1:0]};
  assign flash_wr   = xwr_req && pwe;
  assign xram_wr    = xwr_req && !pwe;
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fec_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int PG_W   = 6,
  parameter int CPU_AW = 16,
  parameter int CNT_W  = 8,
  localparam int FLASH_AW = BANK_W + CPU_AW - 1,
  localparam int PAGE_W   = PG_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sfr_we,
  input  logic [7:0]          sfr_addr,
  input  logic [7:0]          sfr_wdata,
  output logic [7:0]          sfr_rdata,
  input  logic                irq_en,
  input  logic                dbg_en,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic                xwr_req,
  output logic [FLASH_AW-1:0] flash_addr,
  output logic                flash_wr,
  output logic                xram_wr,
  output logic                erase_valid,
  input  logic                erase_ready,
  output logic                erase_mass,
  output logic [PAGE_W-1:0]   erase_page,
  input  logic                flash_done,
  output logic                busy,
  output logic                arm_page,
  output logic                arm_mass,
  output logic [CNT_W-1:0]    rej_cnt
);
  logic [BANK_W-1:0] bank_q;
  logic [PG_W-1:0]   pgadr_q;
  logic              pwe_q;
  logic              start_page, start_mass, wr_cmd;

  assign wr_cmd = sfr_we && (sfr_addr == A_ERASE);

  fec_regs #(.BANK_W(BANK_W), .PG_W(PG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (sfr_we),
    .addr       (sfr_addr),
    .wdata      (sfr_wdata),
    .irq_en     (irq_en),
    .take_page  (start_page),
    .take_mass  (start_mass),
    .clear_bank (start_page || start_mass),
    .bank_q     (bank_q),
    .pgadr_q    (pgadr_q),
    .arm_page_q (arm_page),
    .arm_mass_q (arm_mass),
    .pwe_q      (pwe_q),
    .rdata      (sfr_rdata)
  );

  fec_seq #(.PG_W(PG_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_cmd      (wr_cmd),
    .wdata       (sfr_wdata),
    .arm_page    (arm_page),
    .arm_mass    (arm_mass),
    .dbg_en      (dbg_en),
    .bank_lsb    (bank_q[0]),
    .pgadr       (pgadr_q),
    .erase_ready (erase_ready),
    .flash_done  (flash_done),
    .start_page  (start_page),
    .start_mass  (start_mass),
    .busy        (busy),
    .erase_valid (erase_valid),
    .erase_mass  (erase_mass),
    .erase_page  (erase_page),
    .rej_cnt     (rej_cnt)
  );

  fec_map #(.BANK_W(BANK_W), .CPU_AW(CPU_AW)) u_map (
    .cpu_addr   (cpu_addr),
    .bank       (bank_q),
    .xwr_req    (xwr_req),
    .pwe        (pwe_q),
    .flash_addr (flash_addr),
    .flash_wr   (flash_wr),
    .xram_wr    (xram_wr)
  );
endmodule

// File: rtl/fec_chk.sv
module fec_chk
  import fec_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int PAGE_W = 7,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sfr_we,
  input logic [7:0]        sfr_addr,
  input logic [7:0]        sfr_wdata,
  input logic              irq_en,
  input logic              dbg_en,
  input logic              erase_valid,
  input logic              erase_ready,
  input logic              erase_mass,
  input logic [PAGE_W-1:0] erase_page,
  input logic              flash_done,
  input logic              busy,
  input logic              arm_page,
  input logic              flash_wr,
  input logic              xram_wr,
  input logic [CNT_W-1:0]  rej_cnt,
  input logic [BANK_W-1:0] bank_q,
  input logic              pwe_q
);
  logic cmd_page_wr, cmd_zero_wr;
  assign cmd_page_wr = sfr_we && sfr_addr == A_ERASE && sfr_wdata == CMD_PAGE;
  assign cmd_zero_wr = sfr_we && sfr_addr == A_ERASE && sfr_wdata == CMD_DONE;

  // R3
  steer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_wr && xram_wr));

  // R4
  pwe_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_en) |-> $stable(pwe_q));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid && !erase_ready |=> erase_valid && $stable(erase_page) && $stable(erase_mass));

  // R10
  busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(flash_done || cmd_zero_wr));

  // R8
  arm_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arm_page) |-> $past(cmd_page_wr));

  // R9
  bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bank_q == '0);

  // R6
  mass_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && erase_mass |-> $past(dbg_en));

  // R7
  rej_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_cnt == $past(rej_cnt)) || (rej_cnt == CNT_W'($past(rej_cnt) + 1'b1)));
endmodule

bind flash_erase_ctrl fec_chk #(.BANK_W(BANK_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sfr_we      (sfr_we),
  .sfr_addr    (sfr_addr),
  .sfr_wdata   (sfr_wdata),
  .irq_en      (irq_en),
  .dbg_en      (dbg_en),
  .erase_valid (erase_valid),
  .erase_ready (erase_ready),
  .erase_mass  (erase_mass),
  .erase_page  (erase_page),
  .flash_done  (flash_done),
  .busy        (busy),
  .arm_page    (arm_page),
  .flash_wr    (flash_wr),
  .xram_wr     (xram_wr),
  .rej_cnt     (rej_cnt),
  .bank_q      (bank_q),
  .pwe_q       (pwe_q)
);

// File: tb/sim_flash_erase_ctrl.sv
`timescale 1ns/1ps
module sim_flash_erase_ctrl;
  localparam logic [7:0] RB = 8'h10, RE = 8'h11, RC = 8'h12, RP = 8'h13;
  localparam int STUB_LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        irq_en = 1'b0, dbg_en = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        xwr_req = 1'b0;
  logic [16:0] flash_addr;
  logic        flash_wr, xram_wr, erase_valid, erase_mass, busy, arm_page, arm_mass;
  logic        erase_ready, flash_done;
  logic [6:0]  erase_page;
  logic [7:0]  rej_cnt;

  always #2 clk = ~clk;

  flash_erase_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_en(irq_en), .dbg_en(dbg_en),
    .cpu_addr(cpu_addr), .xwr_req(xwr_req), .flash_addr(flash_addr),
    .flash_wr(flash_wr), .xram_wr(xram_wr), .erase_valid(erase_valid),
    .erase_ready(erase_ready), .erase_mass(erase_mass), .erase_page(erase_page),
    .flash_done(flash_done), .busy(busy), .arm_page(arm_page), .arm_mass(arm_mass),
    .rej_cnt(rej_cnt)
  );

  // behavioural flash stub
  int         stub_cnt;
  int         fin_cnt;
  logic       stub_mass;
  logic [6:0] stub_page;
  always @(posedge clk) begin
    if (!rst_n) begin
      erase_ready <= 1'b0; flash_done <= 1'b0; stub_cnt <= 0; fin_cnt <= 0;
      stub_mass <= 1'b0; stub_page <= '0;
    end else begin
      erase_ready <= erase_valid && !erase_ready;
      flash_done  <= (stub_cnt == 1);
      if (flash_done) fin_cnt <= fin_cnt + 1;
      if (erase_valid && erase_ready) begin
        stub_cnt  <= STUB_LAT;
        stub_mass <= erase_mass;
        stub_page <= erase_page;
      end else if (stub_cnt > 0) stub_cnt <= stub_cnt - 1;
    end
  end

  int n_chk = 0, n_err = 0;

  // model state
  logic [1:0] m_bank;
  logic [5:0] m_pg;
  logic       m_arm_page, m_arm_mass, m_pwe, m_busy, m_zero, m_exp_mass;
  logic [6:0] m_exp_page;
  int         m_rej, m_fin0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_map(input logic [1:0] b, input logic [15:0] a);
    return a[15] ? {b, a[14:0]} : {2'b00, a[14:0]};
  endfunction

  task automatic model_reset();
    m_bank = 0; m_pg = 0; m_arm_page = 0; m_arm_mass = 0; m_pwe = 0;
    m_busy = 0; m_zero = 0; m_exp_mass = 0; m_exp_page = 0; m_rej = 0; m_fin0 = 0;
  endtask

  task automatic settle();
    if (m_busy && m_zero && fin_cnt != m_fin0) begin
      check(stub_mass == m_exp_mass, "R5 R6 erase kind at flash", stub_mass, m_exp_mass);
      check(stub_page == m_exp_page, "R5 erase page at flash", stub_page, m_exp_page);
      m_busy = 0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    settle();
    case (a)
      RB: m_bank = d[1:0];
      RC: begin m_arm_mass = d[1]; if (!irq_en) m_pwe = d[0]; end
      RP: begin m_pg = d[7:2]; m_arm_page = 1; end
      RE: begin
        if (d == 8'h00) begin
          if (m_busy) m_zero = 1;
        end else if (!m_busy && d == 8'h55 && m_arm_page) begin
          m_busy = 1; m_zero = 0; m_fin0 = fin_cnt; m_exp_mass = 0;
          m_exp_page = {m_bank[0], m_pg}; m_arm_page = 0; m_bank = 0;
        end else if (!m_busy && d == 8'hAA && m_arm_mass && dbg_en) begin
          m_busy = 1; m_zero = 0; m_fin0 = fin_cnt; m_exp_mass = 1;
          m_exp_page = 0; m_arm_mass = 0; m_bank = 0;
        end else if (m_rej < 255) m_rej++;
      end
      default: ;
    endcase
    sfr_we = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    sfr_addr = a; #0.5; v = sfr_rdata;
  endtask

  task automatic check_all();
    logic [7:0] v;
    logic [15:0] ca;
    @(negedge clk);
    settle();
    check(busy == m_busy, "R10 busy", busy, m_busy);
    check(arm_page == m_arm_page, "R8 arm_page", arm_page, m_arm_page);
    check(arm_mass == m_arm_mass, "R8 arm_mass", arm_mass, m_arm_mass);
    check(rej_cnt == m_rej[7:0], "R7 rej_cnt", rej_cnt, m_rej);
    rd(RB, v); check(v == {6'b0, m_bank}, "R9 bank readback", v, m_bank);
    rd(RC, v); check(v == {6'b0, m_arm_mass, m_pwe}, "R4 ctrl readback", v, {m_arm_mass, m_pwe});
    rd(RP, v); check(v == {m_pg, 2'b00}, "R5 page readback", v, {m_pg, 2'b00});
    ca = 16'($urandom); cpu_addr = ca; xwr_req = 1'($urandom);
    #0.5;
    check(flash_addr == exp_map(m_bank, ca), "R2 flash_addr", flash_addr, exp_map(m_bank, ca));
    check(flash_wr == (xwr_req && m_pwe) && xram_wr == (xwr_req && !m_pwe),
          "R3 write steering", {flash_wr, xram_wr}, {xwr_req && m_pwe, xwr_req && !m_pwe});
    xwr_req = 0;
  endtask

  task automatic wait_fin(input int base);
    int guard = 0;
    while (fin_cnt == base && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    check(busy == 0 && erase_valid == 0, "R1 busy/valid after reset", {busy, erase_valid}, 0);
    check(arm_page == 0 && arm_mass == 0 && rej_cnt == 0, "R1 flags after reset",
          {arm_page, arm_mass, rej_cnt}, 0);
    rd(RB, v); check(v == 0, "R1 bank after reset", v, 0);
    rd(RC, v); check(v == 0, "R1 ctrl after reset", v, 0);
    rd(RP, v); check(v == 0, "R1 page after reset", v, 0);

    // R2 mapping
    wr(RB, 8'h02);
    cpu_addr = 16'h9234; #0.5;
    check(flash_addr == 17'h11234, "R2 upper window", flash_addr, 17'h11234);
    cpu_addr = 16'h1234; #0.5;
    check(flash_addr == 17'h01234, "R2 lower window", flash_addr, 17'h01234);

    // R3 / R4 steering and interrupt lock
    wr(RC, 8'h01);
    xwr_req = 1; #0.5;
    check(flash_wr == 1 && xram_wr == 0, "R3 steer to flash", {flash_wr, xram_wr}, 2'b10);
    irq_en = 1;
    wr(RC, 8'h00);
    rd(RC, v); check(v[0] == 1, "R4 pwe held while irq_en", v[0], 1);
    #0.5; check(flash_wr == 1, "R4 still steering to flash", flash_wr, 1);
    irq_en = 0;
    wr(RC, 8'h00);
    #0.5; check(flash_wr == 0 && xram_wr == 1, "R3 steer to xram", {flash_wr, xram_wr}, 2'b01);
    xwr_req = 0;

    // R5 / R9 / R10 page erase, done before zero write
    wr(RB, 8'h03);
    wr(RP, 8'h28);
    base = fin_cnt;
    @(negedge clk);
    sfr_we = 1; sfr_addr = RE; sfr_wdata = 8'h55;
    @(negedge clk);
    sfr_we = 0;
    m_busy = 1; m_zero = 0; m_fin0 = base; m_exp_mass = 0; m_exp_page = 7'h4A;
    m_arm_page = 0; m_bank = 0;
    check(busy == 1 && erase_valid == 1, "R5 page erase started", {busy, erase_valid}, 2'b11);
    check(erase_mass == 0 && erase_page == 7'h4A, "R5 page payload",
          {erase_mass, erase_page}, 8'h4A);
    rd(RB, v); check(v == 0, "R9 bank cleared on erase", v, 0);
    check(arm_page == 0, "R8 page arming consumed", arm_page, 0);
    wait_fin(base);
    check(busy == 1, "R10 busy held until zero write", busy, 1);
    wr(RE, 8'h00);
    check(busy == 0, "R10 busy released by zero write", busy, 0);
    settle();

    // R8 / R7 re-issue without re-arming
    wr(RE, 8'h55);
    check(busy == 0 && rej_cnt == 1, "R8 unarmed page command rejected", {busy, rej_cnt}, 1);

    // R6 mass erase needs debug port, zero write before done
    wr(RC, 8'h02);
    dbg_en = 0;
    wr(RE, 8'hAA);
    check(busy == 0 && arm_mass == 1, "R6 mass rejected without debug", {busy, arm_mass}, 1);
    dbg_en = 1;
    base = fin_cnt;
    wr(RE, 8'hAA);
    check(busy == 1 && erase_mass == 1, "R6 mass erase started", {busy, erase_mass}, 2'b11);
    check(arm_mass == 0, "R8 mass arming consumed", arm_mass, 0);
    wr(RE, 8'h00);
    check(busy == 1, "R10 busy held until flash done", busy, 1);
    wr(RE, 8'h55);
    wait_fin(base);
    check(busy == 0, "R10 busy released after done", busy, 0);
    check(rej_cnt == 8'd3, "R7 rejects counted", rej_cnt, 3);
    wr(RE, 8'h5A);
    check(rej_cnt == 8'd4 && busy == 0, "R7 other pattern ignored", {busy, rej_cnt}, 4);
    check_all();

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom % 11);
      case (op)
        0, 1: wr(RE, 8'h55);
        2:    wr(RE, 8'hAA);
        3, 4: wr(RE, 8'h00);
        5:    wr(RE, 8'($urandom));
        6:    wr(RP, 8'($urandom));
        7:    begin irq_en = 1'($urandom); wr(RC, 8'($urandom)); end
        8:    wr(RB, 8'($urandom));
        9:    begin dbg_en = 1'($urandom); irq_en = 1'($urandom); end
        default: repeat (3) @(negedge clk);
      endcase
      check_all();
    end

    // R7 saturation
    for (int i = 0; i < 260; i++) wr(RE, 8'h33);
    check(rej_cnt == 8'hFF, "R7 reject count saturates", rej_cnt, 8'hFF);
    check_all();

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule